// File: doc/BRIEF.md
# Page-Walk Path Cache

This block sits beside a hardware page walker for a four-level radix page table. Each slot remembers one complete upper-level walk: the three 9-bit virtual index fields used at the top, middle and lower-middle levels, and the table page numbers those three entries pointed to. The bottom-level entries are not kept here, because the TLB holds them. On a TLB miss the walker presents the virtual address. The block reports the deepest level at which any slot agrees with the address, and the physical page number of the next table to read. The walker can then skip every memory access above that point.

When a walk completes without a fault, the walker reports the walked address and the three table pointers. The path is then installed as one unit, or refreshed in place if it is already cached, and it becomes the most recently used slot. A walk that ends on a null entry is not installed. Replacement is least-recently-used over whole paths. A lookup that hits also moves its slot to the most recent position. An explicit flush, or any change of the root table page number, empties the cache in one cycle.

Top module: `tpc_path_cache`

## Requirements
- R1: After reset every slot is empty, so a lookup returns resume level 0, and on level 0 the returned page number is the current `root_ppn`.
- R2: `lk_rsp_valid` is high in exactly the cycle after a cycle with `lk_valid` high. The level and page number appear in that cycle and reflect the cache state before the edge.
- R3: The index fields are bits 47:39 (top level), 38:30 (second) and 29:21 (third). A slot matches to depth 1, 2 or 3 when the fields from the top down to that level all equal its stored fields. Level k returns the stored pointer taken from the level-k entry: 1 gives the second-level table, 2 the third-level table, 3 the bottom-level table.
- R4: The returned level is the deepest match over all valid slots. Among slots tied at that depth, the lowest-numbered slot supplies the pointer.
- R5: A fill with `fill_fault` high installs nothing and changes neither the slots nor the LRU order.
- R6: A fill of a path that is not fully cached is written into the lowest-numbered empty slot. If no slot is empty, it is written into the least recently used slot. The written slot becomes most recently used.
- R7: A fill whose three index fields already sit in a slot overwrites that slot's pointers and makes it most recently used. No other slot is evicted.
- R8: A lookup with level above 0 makes the slot that supplied the answer (per R4) most recently used.
- R9: `flush` empties every slot at the next edge. A lookup in the same cycle answers level 0, and a fill in the same cycle is dropped.
- R10: A cycle in which `root_ppn` differs from its value in the previous cycle behaves exactly like a flush.
- R11: When a fill and a hitting lookup arrive in the same cycle, only the fill updates the LRU order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ppn | input | PPN_W | Page number of the top-level table |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to look up |
| lk_rsp_valid | output | 1 | Lookup answer valid |
| lk_rsp_level | output | 2 | Resume level 0..3 |
| lk_rsp_ppn | output | PPN_W | Next table page number, or root on level 0 |
| fill_valid | input | 1 | Walk completed |
| fill_fault | input | 1 | Walk ended on a null entry |
| fill_vaddr | input | 48 | Walked virtual address |
| fill_ptr_l4 | input | PPN_W | Second-level table pointer from the top entry |
| fill_ptr_l3 | input | PPN_W | Third-level table pointer from the second entry |
| fill_ptr_l2 | input | PPN_W | Bottom table pointer from the third entry |

## Verification
Random lookups and fills draw index fields from a small pool. This makes full hits, hits that stop at the first or second level, and misses all frequent, so the depth selection of R3 and R4 is tested against each level boundary. Fills outnumber the slots, which forces evictions. An LRU order that drifts therefore shows up later as a wrong level. Directed sequences isolate a faulting fill, an in-place refresh with changed pointers, flush and root changes that coincide with lookups and fills, and a fill colliding with a hit. Each of these separates one priority rule from the others.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int VA_W   = 48;
  localparam int IDX_W  = 9;
  localparam int LEVELS = 3;
  localparam int PG_SH  = 12;
  localparam int TAG_W  = IDX_W * LEVELS;

  typedef logic [1:0] lvl_t;

  // field j: 0 = top level, 1 = second, 2 = third
  function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
    logic [TAG_W-1:0] t;
    for (int j = 0; j < LEVELS; j++)
      t[j*IDX_W +: IDX_W] = va[PG_SH + IDX_W*(LEVELS-j) +: IDX_W];
    return t;
  endfunction

  // number of leading fields (from the top) that agree
  function automatic lvl_t match_depth(input logic [TAG_W-1:0] a,
                                       input logic [TAG_W-1:0] b);
    lvl_t d;
    logic run;
    d   = '0;
    run = 1'b1;
    for (int j = 0; j < LEVELS; j++) begin
      run = run && (a[j*IDX_W +: IDX_W] == b[j*IDX_W +: IDX_W]);
      if (run) d = lvl_t'(j + 1);
    end
    return d;
  endfunction
endpackage

// File: rtl/tpc_match.sv
module tpc_match
  import tpc_pkg::*;
(
  input  logic             slot_valid,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic [TAG_W-1:0] key_tag,
  output lvl_t             depth
);
  assign depth = slot_valid ? match_depth(slot_tag, key_tag) : lvl_t'(0);
endmodule

// File: rtl/tpc_select.sv
module tpc_select
  import tpc_pkg::*;
#(
  parameter int N_SLOTS = 4,
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic [2*N_SLOTS-1:0] depths,
  output lvl_t                 best_lvl,
  output logic [IW-1:0]        best_idx
);
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (depths[2*i +: 2] != 2'd0 && depths[2*i +: 2] >= best_lvl) begin
        best_lvl = depths[2*i +: 2];
        best_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tpc_lru.sv
module tpc_lru #(
  parameter int N_SLOTS = 4,
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_en,
  input  logic [IW-1:0]         touch_idx,
  input  logic [N_SLOTS-1:0]    valid_vec,
  output logic [N_SLOTS*IW-1:0] ages,
  output logic [IW-1:0]         victim
);
  logic [IW-1:0] age_q [N_SLOTS];
  logic [IW-1:0] touch_age;

  assign touch_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SLOTS; i++) age_q[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N_SLOTS; i++) begin
        if (IW'(i) == touch_idx)       age_q[i] <= '0;
        else if (age_q[i] < touch_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N_SLOTS; i++)
      if (age_q[i] == IW'(N_SLOTS - 1)) victim = IW'(i);
    for (int i = N_SLOTS - 1; i >= 0; i--)
      if (!valid_vec[i]) victim = IW'(i);
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_age
    assign ages[g*IW +: IW] = age_q[g];
  end
endmodule

// File: rtl/tpc_path_cache.sv
module tpc_path_cache
  import tpc_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int PPN_W   = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PPN_W-1:0] root_ppn,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_rsp_valid,
  output logic [1:0]       lk_rsp_level,
  output logic [PPN_W-1:0] lk_rsp_ppn,
  input  logic             fill_valid,
  input  logic             fill_fault,
  input  logic [VA_W-1:0]  fill_vaddr,
  input  logic [PPN_W-1:0] fill_ptr_l4,
  input  logic [PPN_W-1:0] fill_ptr_l3,
  input  logic [PPN_W-1:0] fill_ptr_l2
);
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic [N_SLOTS-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [N_SLOTS];
  logic [PPN_W-1:0]   ptr_q [N_SLOTS][LEVELS];
  logic [PPN_W-1:0]   root_q;

  logic [2*N_SLOTS-1:0] lk_depths, fl_depths;
  lvl_t                 lk_lvl, fl_lvl;
  logic [IW-1:0]        lk_idx, fl_idx, victim, fill_slot, touch_idx;
  logic [N_SLOTS*IW-1:0] ages;

  // named events used by the checker
  logic flush_any, fill_do, fill_refresh, hit_touch, touch_en;

  logic [TAG_W-1:0] lk_key, fl_key;
  assign lk_key = tag_of(lk_vaddr);
  assign fl_key = tag_of(fill_vaddr);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    tpc_match u_lk (.slot_valid(valid_q[g]), .slot_tag(tag_q[g]),
                    .key_tag(lk_key), .depth(lk_depths[2*g +: 2]));
    tpc_match u_fl (.slot_valid(valid_q[g]), .slot_tag(tag_q[g]),
                    .key_tag(fl_key), .depth(fl_depths[2*g +: 2]));
  end

  tpc_select #(.N_SLOTS(N_SLOTS)) u_sel_lk (.depths(lk_depths), .best_lvl(lk_lvl), .best_idx(lk_idx));
  tpc_select #(.N_SLOTS(N_SLOTS)) u_sel_fl (.depths(fl_depths), .best_lvl(fl_lvl), .best_idx(fl_idx));

  assign flush_any    = flush || (root_ppn != root_q);
  assign fill_do      = fill_valid && !fill_fault && !flush_any;
  assign fill_refresh = (fl_lvl == lvl_t'(LEVELS));
  assign fill_slot    = fill_refresh ? fl_idx : victim;
  assign hit_touch    = lk_valid && !flush_any && (lk_lvl != 2'd0);
  assign touch_en     = fill_do || hit_touch;
  assign touch_idx    = fill_do ? fill_slot : lk_idx;

  tpc_lru #(.N_SLOTS(N_SLOTS)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid_vec(valid_q), .ages(ages), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      root_q  <= root_ppn;
    end else begin
      root_q <= root_ppn;
      if (flush_any) valid_q <= '0;
      else if (fill_do) valid_q[fill_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fill_slot]    <= fl_key;
      ptr_q[fill_slot][0] <= fill_ptr_l4;
      ptr_q[fill_slot][1] <= fill_ptr_l3;
      ptr_q[fill_slot][2] <= fill_ptr_l2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_rsp_level <= '0;
      lk_rsp_ppn   <= '0;
    end else begin
      lk_rsp_valid <= lk_valid;
      if (flush_any || lk_lvl == 2'd0) begin
        lk_rsp_level <= '0;
        lk_rsp_ppn   <= root_ppn;
      end else begin
        lk_rsp_level <= lk_lvl;
        lk_rsp_ppn   <= ptr_q[lk_idx][lk_lvl - 2'd1];
      end
    end
  end
endmodule

// File: rtl/tpc_path_cache_chk.sv
module tpc_path_cache_chk #(
  parameter int N_SLOTS = 4,
  parameter int PPN_W   = 36,
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PPN_W-1:0]      root_ppn,
  input logic                  lk_valid,
  input logic                  lk_rsp_valid,
  input logic [1:0]            lk_rsp_level,
  input logic                  fill_valid,
  input logic                  fill_fault,
  input logic [N_SLOTS-1:0]    valid_q,
  input logic [N_SLOTS*IW-1:0] ages,
  input logic                  flush_any
);
  logic [N_SLOTS-1:0] is_mru;
  always_comb
    for (int i = 0; i < N_SLOTS; i++) is_mru[i] = (ages[i*IW +: IW] == '0);

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_rsp_valid);
  a_r2_no_stray_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_rsp_valid);
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_any |=> (valid_q == '0));
  a_r9_flush_lookup_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_any && lk_valid) |=> (lk_rsp_level == 2'd0));
  a_r5_fault_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_fault && !flush_any) |=> $stable(valid_q));
  a_r6_single_mru: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_mru) == 1);
  a_r10_root_change_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(root_ppn) |-> flush_any);
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (valid_q == '0));
endmodule

bind tpc_path_cache tpc_path_cache_chk #(.N_SLOTS(N_SLOTS), .PPN_W(PPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn), .lk_valid(lk_valid),
  .lk_rsp_valid(lk_rsp_valid), .lk_rsp_level(lk_rsp_level),
  .fill_valid(fill_valid), .fill_fault(fill_fault), .valid_q(valid_q),
  .ages(ages), .flush_any(flush_any)
);

// File: tb/tpc_path_cache_tb.sv
module tpc_path_cache_tb;
  localparam int N  = 4;
  localparam int PW = 36;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] root_ppn = 36'h0000AAAAA;
  logic flush = 0, lk_valid = 0, fill_valid = 0, fill_fault = 0;
  logic [47:0] lk_vaddr = '0, fill_vaddr = '0;
  logic [PW-1:0] f4 = '0, f3 = '0, f2 = '0;
  logic lk_rsp_valid;
  logic [1:0] lk_rsp_level;
  logic [PW-1:0] lk_rsp_ppn;

  always #4 clk = ~clk;

  tpc_path_cache #(.N_SLOTS(N), .PPN_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn), .flush(flush),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_rsp_valid(lk_rsp_valid),
    .lk_rsp_level(lk_rsp_level), .lk_rsp_ppn(lk_rsp_ppn),
    .fill_valid(fill_valid), .fill_fault(fill_fault), .fill_vaddr(fill_vaddr),
    .fill_ptr_l4(f4), .fill_ptr_l3(f3), .fill_ptr_l2(f2)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  bit         m_v   [N];
  int         m_ix  [N][3];
  logic [PW-1:0] m_p [N][3];
  int         m_age [N];
  logic [PW-1:0] m_root;

  function automatic int fld(logic [47:0] va, int j);
    return int'((va >> (39 - 9*j)) & 48'h1FF);
  endfunction

  function automatic logic [47:0] mk_va(int a, int b, int c);
    return (48'(a) << 39) | (48'(b) << 30) | (48'(c) << 21) | 48'($urandom & 32'h1FFFFF);
  endfunction

  function automatic logic [PW-1:0] tptr(int lv, int a, int b, int c);
    return PW'(lv) << 30 | PW'(a) << 20 | PW'(b) << 10 | PW'(c);
  endfunction

  // deepest match; lowest slot on ties
  function automatic void m_find(logic [47:0] va, output int lvl, output int idx);
    lvl = 0; idx = 0;
    for (int s = 0; s < N; s++) begin
      int d = 0;
      if (m_v[s]) begin
        if (m_ix[s][0] == fld(va, 0)) begin
          d = 1;
          if (m_ix[s][1] == fld(va, 1)) begin
            d = 2;
            if (m_ix[s][2] == fld(va, 2)) d = 3;
          end
        end
      end
      if (d > lvl) begin lvl = d; idx = s; end
    end
  endfunction

  function automatic void m_touch(int s);
    int a = m_age[s];
    for (int i = 0; i < N; i++) if (m_age[i] < a) m_age[i]++;
    m_age[s] = 0;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 0; i < N; i++) if (m_age[i] == N - 1) return i;
    return 0;
  endfunction

  task automatic check(string tag, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already set; predict, advance, check
  task automatic cycle(string tag);
    int el = 0, ei = 0;
    logic [PW-1:0] ep;
    bit fa, had_lk;
    fa = flush || (root_ppn != m_root);
    had_lk = lk_valid;
    ep = root_ppn;
    if (lk_valid && !fa) begin
      m_find(lk_vaddr, el, ei);
      if (el > 0) ep = m_p[ei][el-1];
    end
    if (fa) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else if (fill_valid && !fill_fault) begin
      int fl, fi, s;
      m_find(fill_vaddr, fl, fi);
      s = (fl == 3) ? fi : m_victim();
      m_v[s] = 1;
      for (int j = 0; j < 3; j++) m_ix[s][j] = fld(fill_vaddr, j);
      m_p[s][0] = f4; m_p[s][1] = f3; m_p[s][2] = f2;
      m_touch(s);
    end else if (lk_valid && el > 0) begin
      m_touch(ei);
    end
    m_root = root_ppn;
    @(negedge clk);
    check({tag, " R2 valid"}, lk_rsp_valid == had_lk, lk_rsp_valid, had_lk);
    if (had_lk) begin
      check({tag, " level"}, lk_rsp_level == 2'(el), lk_rsp_level, el);
      check({tag, " ppn"}, lk_rsp_ppn == ep, lk_rsp_ppn, ep);
    end
    lk_valid = 0; fill_valid = 0; fill_fault = 0; flush = 0;
  endtask

  task automatic do_fill(int a, int b, int c, bit fault, string tag);
    fill_valid = 1; fill_fault = fault; fill_vaddr = mk_va(a, b, c);
    f4 = tptr(1, a, 0, 0); f3 = tptr(2, a, b, 0); f2 = tptr(3, a, b, c);
    cycle(tag);
  endtask

  task automatic do_look(int a, int b, int c, string tag);
    lk_valid = 1; lk_vaddr = mk_va(a, b, c);
    cycle(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_age[i] = i; end
    m_root = root_ppn;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 rsp idle after reset", lk_rsp_valid == 0, lk_rsp_valid, 0);
    do_look(1, 1, 1, "R1 empty lookup");
    // R3: levels 1..3 from one path
    do_fill(1, 2, 3, 0, "R6 first install");
    do_look(1, 2, 3, "R3 full hit");
    do_look(1, 2, 7, "R3 depth two");
    do_look(1, 5, 3, "R3 depth one");
    do_look(2, 2, 3, "R3 miss");
    // R4: deeper slot wins
    do_fill(1, 4, 0, 0, "R6 second install");
    do_look(1, 4, 9, "R4 deepest");
    // R5: faulting fill
    do_fill(3, 3, 3, 1, "R5 fault fill");
    do_look(3, 3, 3, "R5 not installed");
    // R6: fill past capacity, evict LRU
    do_fill(2, 0, 0, 0, "R6 fill3");
    do_fill(2, 1, 0, 0, "R6 fill4");
    do_look(1, 2, 3, "R8 touch oldest");
    do_fill(5, 5, 5, 0, "R6 evict lru");
    do_look(1, 4, 0, "R6 evicted path");
    do_look(1, 2, 3, "R8 kept path");
    // R7: refresh in place with new pointers
    flush = 1; cycle("R9 flush");
    do_look(1, 2, 3, "R9 after flush");
    do_fill(6, 6, 6, 0, "R7 base");
    fill_valid = 1; fill_vaddr = mk_va(6, 6, 6);
    f4 = 36'h111; f3 = 36'h222; f2 = 36'h333; cycle("R7 refresh");
    do_look(6, 6, 6, "R7 new ptr");
    do_look(6, 6, 1, "R7 new mid ptr");
    // R9: flush with fill and lookup together
    flush = 1; lk_valid = 1; lk_vaddr = mk_va(6, 6, 6);
    fill_valid = 1; fill_vaddr = mk_va(7, 7, 7); cycle("R9 flush coincident");
    do_look(7, 7, 7, "R9 fill dropped");
    // R10: root change
    do_fill(4, 4, 4, 0, "R10 setup");
    root_ppn = 36'h0000BBBBB; lk_valid = 1; lk_vaddr = mk_va(4, 4, 4);
    cycle("R10 root change");
    do_look(4, 4, 4, "R10 emptied");
    // R11: fill and hit same cycle
    for (int i = 0; i < N; i++) do_fill(i + 8, 0, 0, 0, "R11 setup");
    lk_valid = 1; lk_vaddr = mk_va(8, 0, 0);
    fill_valid = 1; fill_vaddr = mk_va(12, 0, 0);
    f4 = tptr(1, 12, 0, 0); f3 = tptr(2, 12, 0, 0); f2 = tptr(3, 12, 0, 0);
    cycle("R11 collide");
    do_fill(13, 0, 0, 0, "R11 next evict");
    do_look(8, 0, 0, "R11 lookup did not touch");
    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      lk_valid = ($urandom_range(0, 9) < 7);
      lk_vaddr = mk_va($urandom_range(0, 2), $urandom_range(0, 2), $urandom_range(0, 3));
      if ($urandom_range(0, 9) < 3) begin
        int a = $urandom_range(0, 2), b = $urandom_range(0, 2), c = $urandom_range(0, 3);
        fill_valid = 1; fill_fault = ($urandom_range(0, 9) == 0);
        fill_vaddr = mk_va(a, b, c);
        f4 = tptr(1, a, 0, 0); f3 = tptr(2, a, b, 0); f2 = tptr(3, a, b, c);
      end
      flush = (r < 2);
      if (r == 99) root_ppn = root_ppn + 36'h10;
      cycle("R3 R4 R6 R8 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule